// File: doc/BRIEF.md
# Destination Bitmask Packet Replicator

This block takes one packetized valid/ready stream, together with a destination bitmask that comes with the packet's first beat, and sends every beat of the packet to each output port whose bit is set in the mask. Several set bits mean a multicast: the packet goes out on all of those ports together, beat by beat. There is no storage for data. The input beat stays at the input until every selected port has taken it. Only then does the input advance.

All outputs share one data, strobe and last bus. Each output has its own valid and ready. The mask is sampled on the first beat of a packet and held for every later beat, so the destination field on those later beats has no effect. An output may be ready before the others. It takes the beat once, and its valid then drops until the input moves on. Every selected output therefore sees each beat exactly once.

Back-pressure rules are as follows. Input ready is high only when every selected output has taken the current beat or is taking it in this cycle. Input ready never depends on outputs that are not selected. The upstream source must hold its valid, data, strobe, last and destination steady while input ready is low. A packet whose mask is all zeros is accepted at full rate and discarded.

Top module: `pkt_fanout`

## Requirements
- R1: After reset no output valid is asserted, and the first accepted beat is treated as the first beat of a packet.
- R2: Input ready is high exactly when, for every selected port, that port has already taken the current beat or its out_ready is high. A beat is consumed when in_valid and in_ready are both high.
- R3: The mask is taken from in_dest on the first beat of a packet and used for all later beats up to the in_last beat. On those later beats, in_dest has no effect on any output.
- R4: An output whose bit is clear in the active mask keeps out_valid low.
- R5: Each selected output receives each input beat exactly once. After it has taken a beat, its out_valid stays low until the input beat is consumed.
- R6: A packet whose mask is all zeros is consumed with in_ready high on every beat, regardless of out_ready, and no output valid is raised.
- R7: The beat after a consumed in_last beat is the first beat of a new packet and takes a fresh mask.
- R8: out_data, out_strb and out_last equal in_data, in_strb and in_last in the same cycle. Strobes are passed through unaltered, including the low tail bytes of a packet's final beat.
- R9: Mask bit i selects output port i. With the default eight ports, bits 0 to 3 are network ports 0 to 3 and bits 4 to 7 are host ports 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted by all selected ports |
| in_data | input | DATA_W | Input payload |
| in_strb | input | STRB_W | Input byte strobes (aligned tail) |
| in_last | input | 1 | Final beat of packet |
| in_dest | input | NUM_OUT | Destination bitmask, meaningful on first beat |
| out_valid | output | NUM_OUT | Per-port beat valid |
| out_ready | input | NUM_OUT | Per-port beat ready |
| out_data | output | DATA_W | Shared payload to all ports |
| out_strb | output | STRB_W | Shared byte strobes |
| out_last | output | 1 | Shared end-of-packet flag |

## Verification
The hardest situation to reach from the ports is partial acceptance. Some selected ports take a beat while others stall, and the input beat must then stay put without sending a second copy to the ports that already took it. It is harder still when this happens on a later beat whose in_dest field disagrees with the held mask. To get there, the stimulus toggles each out_ready at random every cycle and scrambles in_dest on non-first beats. Directed packets add an all-zero mask under full stall, an all-ports single beat and single-port masks at both ends. The bench also counts each port's transfers and XOR-folds their payloads, and compares these totals against the packets that were sent.

// File: rtl/fanout_pkg.sv
package fanout_pkg;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_NUM_OUT = 8;
  localparam int unsigned NET_PORT_BASE  = 0;
  localparam int unsigned HOST_PORT_BASE = 4;
endpackage

// File: rtl/fanout_mask_hold.sv
module fanout_mask_hold #(
  parameter int unsigned NUM_OUT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_fire,
  input  logic               in_last,
  input  logic [NUM_OUT-1:0] in_dest,
  output logic               first_beat,
  output logic [NUM_OUT-1:0] act_mask
);
  logic               sop_q;
  logic [NUM_OUT-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sop_q  <= 1'b1;
      mask_q <= '0;
    end else if (beat_fire) begin
      sop_q <= in_last;
      if (sop_q) mask_q <= in_dest;
    end
  end

  assign first_beat = sop_q;
  assign act_mask   = sop_q ? in_dest : mask_q;

  p_hold_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !in_last) |=> (!first_beat && act_mask == $past(act_mask)));

  p_last_reopen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && in_last) |=> first_beat);
endmodule

// File: rtl/fanout_lane.sv
module fanout_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic sel,
  input  logic beat_fire,
  input  logic out_ready,
  output logic out_valid,
  output logic lane_ok
);
  logic done_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      done_q <= 1'b0;
    else if (beat_fire)              done_q <= 1'b0;
    else if (out_valid && out_ready) done_q <= 1'b1;
  end

  assign out_valid = in_valid && sel && !done_q;
  assign lane_ok   = !sel || done_q || out_ready;

  p_one_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !beat_fire) |=> !out_valid);

  p_clear_on_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> !done_q);
endmodule

// File: rtl/fanout_ready_join.sv
module fanout_ready_join #(
  parameter int unsigned NUM_OUT = 8
) (
  input  logic [NUM_OUT-1:0] lane_ok,
  output logic               all_ok
);
  assign all_ok = &lane_ok;
endmodule

// File: rtl/pkt_fanout.sv
module pkt_fanout
  import fanout_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned NUM_OUT = DEF_NUM_OUT,
  parameter int unsigned STRB_W  = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [STRB_W-1:0]  in_strb,
  input  logic               in_last,
  input  logic [NUM_OUT-1:0] in_dest,
  output logic [NUM_OUT-1:0] out_valid,
  input  logic [NUM_OUT-1:0] out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic [STRB_W-1:0]  out_strb,
  output logic               out_last
);
  logic               first_beat;
  logic [NUM_OUT-1:0] act_mask;
  logic [NUM_OUT-1:0] lane_ok;
  logic               beat_fire;

  assign beat_fire = in_valid && in_ready;

  fanout_mask_hold #(.NUM_OUT(NUM_OUT)) u_mask (
    .clk(clk), .rst_n(rst_n), .beat_fire(beat_fire), .in_last(in_last),
    .in_dest(in_dest), .first_beat(first_beat), .act_mask(act_mask)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    fanout_lane u_lane (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel(act_mask[g]),
      .beat_fire(beat_fire), .out_ready(out_ready[g]),
      .out_valid(out_valid[g]), .lane_ok(lane_ok[g])
    );
  end

  fanout_ready_join #(.NUM_OUT(NUM_OUT)) u_join (
    .lane_ok(lane_ok), .all_ok(in_ready)
  );

  assign out_data = in_data;
  assign out_strb = in_strb;
  assign out_last = in_last;

  p_zero_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && act_mask == '0) |-> (in_ready && out_valid == '0));

  p_unsel_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid & ~act_mask) == '0);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> out_valid == '0);

  p_fire_after_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (!first_beat || $past(first_beat)));
endmodule

// File: tb/test_pkt_fanout.sv
module test_pkt_fanout;
  localparam int DW = 32;
  localparam int NP = 8;
  localparam int SW = DW / 8;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [SW-1:0] in_strb = '0;
  logic          in_last = 1'b0;
  logic [NP-1:0] in_dest = '0;
  logic [NP-1:0] out_valid;
  logic [NP-1:0] out_ready = '0;
  logic [DW-1:0] out_data;
  logic [SW-1:0] out_strb;
  logic          out_last;

  int checks = 0;
  int fails  = 0;
  int ready_mode = 0;
  int pkt_no = 0;

  bit            m_sop = 1'b1;
  logic [NP-1:0] m_mask = '0;
  logic [NP-1:0] m_taken = '0;
  bit            fired;

  int            exp_cnt [NP];
  logic [DW-1:0] exp_x   [NP];
  int            got_cnt [NP];
  logic [DW-1:0] got_x   [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_fanout #(.DATA_W(DW), .NUM_OUT(NP)) i_pkt_fanout (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_strb(in_strb), .in_last(in_last), .in_dest(in_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_strb(out_strb), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] live_mask();
    return m_sop ? in_dest : m_mask;
  endfunction

  function automatic logic [NP-1:0] exp_valid();
    return in_valid ? (live_mask() & ~m_taken) : '0;
  endfunction

  function automatic bit exp_ready();
    return &(~live_mask() | m_taken | out_ready);
  endfunction

  function automatic logic [SW-1:0] tail_strb(input int nbytes);
    return SW'((1 << nbytes) - 1);
  endfunction

  task automatic step();
    logic [NP-1:0] ev;
    logic [NP-1:0] am;
    bit er;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      case (ready_mode)
        1:       out_ready[p] = 1'b0;
        2:       out_ready[p] = 1'b1;
        default: out_ready[p] = ($urandom % 3) != 0;
      endcase
    end
    #1;
    am = live_mask();
    ev = exp_valid();
    er = exp_ready();
    chk((out_valid & ~am) == '0, m_sop ? "R4" : "R3", out_valid, ev);
    chk((out_valid & am) == ev, (m_sop && pkt_no > 0) ? "R7" : "R5", out_valid, ev);
    if (in_valid)
      chk(in_ready == er, (am == '0) ? "R6" : "R2", in_ready, er);
    if (out_valid != '0)
      chk(out_data == in_data && out_strb == in_strb && out_last == in_last,
          "R8", {out_strb, out_data}, {in_strb, in_data});
    for (int p = 0; p < NP; p++)
      if (out_valid[p] && out_ready[p]) begin
        got_cnt[p]++;
        got_x[p] ^= out_data;
      end
    fired = in_valid && er;
    if (fired) begin
      if (m_sop) m_mask = in_dest;
      m_sop   = in_last;
      m_taken = '0;
    end else begin
      m_taken = m_taken | (ev & out_ready);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic send_pkt(input logic [NP-1:0] mask, input int len, input bit scramble);
    for (int b = 0; b < len; b++) begin
      logic [DW-1:0] d;
      d = $urandom;
      if (scramble && ($urandom % 4) == 0) begin
        in_valid = 1'b0;
        step();
      end
      in_valid = 1'b1;
      in_data  = d;
      in_last  = (b == len - 1);
      in_strb  = in_last ? tail_strb(1 + ($urandom % SW)) : '1;
      in_dest  = (b == 0) ? mask : (scramble ? NP'($urandom) : ~mask);
      for (int p = 0; p < NP; p++)
        if (mask[p]) begin
          exp_cnt[p]++;
          exp_x[p] ^= d;
        end
      fired = 1'b0;
      while (!fired) step();
    end
    in_valid = 1'b0;
    pkt_no++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) begin
      exp_cnt[p] = 0; got_cnt[p] = 0; exp_x[p] = '0; got_x[p] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == '0, "R1", out_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: first beat after reset selects from in_dest (mask 0x01, later beats differ: R3)
    ready_mode = 2;
    send_pkt(8'h01, 4, 1'b0);
    // R6: all-zero mask with every output stalled
    ready_mode = 1;
    send_pkt(8'h00, 3, 1'b0);
    // all ports, single beat, random readiness
    ready_mode = 0;
    send_pkt(8'hFF, 1, 1'b0);
    // R9: top host port alone, then network port 0 alone
    send_pkt(8'h80, 2, 1'b1);
    send_pkt(8'h01, 2, 1'b1);
    for (int k = 0; k < 220; k++) begin
      logic [NP-1:0] m;
      int sel;
      sel = $urandom % 8;
      m = (sel == 0) ? '0 : (sel == 1) ? '1 : NP'($urandom);
      send_pkt(m, 1 + ($urandom % 6), 1'b1);
    end
    repeat (2) step();
    for (int p = 0; p < NP; p++) begin
      chk(got_cnt[p] == exp_cnt[p], "R9", got_cnt[p], exp_cnt[p]);
      chk(got_x[p] == exp_x[p], "R8", got_x[p], exp_x[p]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule